// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Counter Stage

This block is a 4-bit counter slice for building longer counters out of identical stages that all run from one clock. Each stage counts on the rising clock edge. It can be preloaded from a data input on a clock edge, and it can be cleared to zero. A carry input and a carry output let stages form a chain: the carry output of one stage drives the carry input of the next, and the first stage has its carry input tied high.

Two elaboration parameters shape the stage. `DECADE` picks a count range of 0 to 9 or a full binary range of 0 to 15. `ASYNC_CLR` picks how the active-low clear acts: either at once, with no clock needed, or at the next rising edge. With the synchronous clear, a short count cycle can be built by decoding the value one below the wrap point and feeding it to the clear. For example, clearing whenever the count is 6 gives a 0..6 cycle.

Clear has the highest priority, then load, then count. Load ignores both the count enable and the carry input. The count advances only when the enable and the carry input are both high. In decade mode a preloaded value from 10 to 15 keeps stepping by one until it wraps from 15 to 0, so the stage cannot lock up.

Top module: `pcnt_stage`

## Requirements
- R1: When clr_n, ld_n, en and ci are all high at a rising edge and q is not the terminal value, q becomes q+1 after that edge.
- R2: A counting edge at the terminal value takes q to 0. The terminal value is 9 (1001) when DECADE=1 and 15 (1111) when DECADE=0.
- R3: With ld_n high and either en or ci low, q holds its value across rising edges.
- R4: With ld_n low and clr_n high at a rising edge, q takes the value of d, whatever en and ci are.
- R5: A low clr_n forces q to 0 and wins over load. With ASYNC_CLR=1, q goes to 0 as soon as clr_n falls, with no clock edge. With ASYNC_CLR=0, q changes only at the next rising edge. Clear is also the stage's reset.
- R6: co is high exactly when ci is high and q equals the terminal value (9 in decade mode, 15 in binary mode).
- R7: In decade mode, a loaded value from 10 to 14 counts to q+1 and 15 counts to 0. co stays low for all of these values.
- R8: Two decade stages on a common clock, with the lower stage's co driving the upper stage's ci, count as a two-digit decimal counter. The upper stage's co is high at 99.
- R9: With ASYNC_CLR=0 and clr_n driven low whenever q equals 6, the stage repeats the cycle 0,1,...,6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge except an asynchronous clear |
| clr_n | input | 1 | Active-low clear to zero; asynchronous or synchronous according to ASYNC_CLR |
| ld_n | input | 1 | Active-low parallel load, sampled on the rising edge |
| d | input | W | Parallel load value |
| en | input | 1 | Count enable |
| ci | input | 1 | Carry input from the previous stage; tie high on the first stage |
| q | output | W | Current count |
| co | output | 1 | Carry output to the next stage's ci |

## Verification
The bench goes after four kinds of fault, each of which gives a distinctive wrong result. The first is the wrap point: a stage that compares against the wrong terminal value would show 10 after 9, or wrap early. The second is out-of-range preloads in decade mode: a design that wraps 12 to 0 would fail, a design that stalls at 15 would lock up, and either would fail the carry check. The third is the clear: the bench checks its timing in both modes, and its priority over load when both are low on the same edge. A synchronous stage that clears early, or an asynchronous one that waits for the clock, would show the wrong value in the middle of the cycle. The fourth is cascade and short-count behaviour: if the carry were wrong, the two-digit counter would read something other than 23 after 123 edges, and the 0..6 cycle would run on to 7.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2
  } op_e;

  // Load outranks counting; clear is handled in the register itself.
  function automatic op_e pick_op(input logic ld_n, input logic en, input logic ci);
    if (!ld_n)          return OP_LOAD;
    else if (en && ci)  return OP_COUNT;
    else                return OP_HOLD;
  endfunction

endpackage

// File: rtl/pcnt_ctrl.sv
module pcnt_ctrl
  import pcnt_pkg::*;
(
  input  logic ld_n,
  input  logic en,
  input  logic ci,
  output op_e  op
);

  always_comb begin
    op = pick_op(ld_n, en, ci);
  end

endmodule

// File: rtl/pcnt_next.sv
module pcnt_next
  import pcnt_pkg::*;
#(
  parameter int W    = 4,
  parameter int TERM = 9
) (
  input  op_e          op,
  input  logic [W-1:0] q,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_nxt,
  output logic         upd
);

  localparam logic [W-1:0] TERM_V = TERM[W-1:0];
  localparam logic [W-1:0] ONE_V  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] stepped;

  // Only the terminal value wraps early; anything above it runs on to the
  // natural wrap at all-ones, so no state can trap the counter.
  always_comb begin
    if (q == TERM_V) stepped = '0;
    else             stepped = q + ONE_V;
  end

  always_comb begin
    unique case (op)
      OP_LOAD:  q_nxt = d;
      OP_COUNT: q_nxt = stepped;
      default:  q_nxt = q;
    endcase
    upd = (op != OP_HOLD);
  end

endmodule

// File: rtl/pcnt_reg.sv
module pcnt_reg #(
  parameter int W         = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         upd,
  input  logic [W-1:0] q_nxt,
  output logic [W-1:0] q
);

  generate
    if (ASYNC_CLR) begin : g_async_clr
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)   q <= '0;
        else if (upd) q <= q_nxt;
      end
    end else begin : g_sync_clr
      always_ff @(posedge clk) begin
        if (!clr_n)   q <= '0;
        else if (upd) q <= q_nxt;
      end
    end
  endgenerate

endmodule

// File: rtl/pcnt_carry.sv
module pcnt_carry #(
  parameter int W    = 4,
  parameter int TERM = 9
) (
  input  logic [W-1:0] q,
  input  logic         ci,
  output logic         co
);

  localparam logic [W-1:0] TERM_V = TERM[W-1:0];

  always_comb begin
    co = ci && (q == TERM_V);
  end

endmodule

// File: rtl/pcnt_stage.sv
module pcnt_stage
  import pcnt_pkg::*;
#(
  parameter int W         = 4,
  parameter bit DECADE    = 1'b1,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic [W-1:0] d,
  input  logic         en,
  input  logic         ci,
  output logic [W-1:0] q,
  output logic         co
);

  localparam int TERM = DECADE ? 9 : ((1 << W) - 1);

  op_e          op;
  logic [W-1:0] q_nxt;
  logic         upd;

  pcnt_ctrl u_ctrl (
    .ld_n (ld_n),
    .en   (en),
    .ci   (ci),
    .op   (op)
  );

  pcnt_next #(.W(W), .TERM(TERM)) u_next (
    .op    (op),
    .q     (q),
    .d     (d),
    .q_nxt (q_nxt),
    .upd   (upd)
  );

  pcnt_reg #(.W(W), .ASYNC_CLR(ASYNC_CLR)) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .upd   (upd),
    .q_nxt (q_nxt),
    .q     (q)
  );

  pcnt_carry #(.W(W), .TERM(TERM)) u_carry (
    .q  (q),
    .ci (ci),
    .co (co)
  );

endmodule

// File: rtl/pcnt_stage_chk.sv
module pcnt_stage_chk #(
  parameter int W         = 4,
  parameter bit DECADE    = 1'b1,
  parameter bit ASYNC_CLR = 1'b0
) (
  input logic         clk,
  input logic         clr_n,
  input logic         ld_n,
  input logic [W-1:0] d,
  input logic         en,
  input logic         ci,
  input logic [W-1:0] q,
  input logic         co
);

  localparam int           TERM   = DECADE ? 9 : ((1 << W) - 1);
  localparam logic [W-1:0] TERM_V = TERM[W-1:0];
  localparam logic [W-1:0] ONE_V  = {{(W-1){1'b0}}, 1'b1};

  assert_step_R1: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && en && ci && q != TERM_V) |=> (q == $past(q) + ONE_V));

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && en && ci && q == TERM_V) |=> (q == '0));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && !(en && ci)) |=> $stable(q));

  assert_load_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (!ld_n) |=> (q == $past(d)));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!clr_n)
    $rose(clr_n) |-> (q == '0));

  assert_carry_in_R6: assert property (@(posedge clk) disable iff (!clr_n)
    co |-> ci);

  assert_carry_wrap_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (co && en && ld_n) |=> (q == '0));

  generate
    if (DECADE) begin : g_dec_chk
      assert_in_range_R7: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && q <= TERM_V) |=> (q <= TERM_V));
    end
  endgenerate

endmodule

bind pcnt_stage pcnt_stage_chk #(.W(W), .DECADE(DECADE), .ASYNC_CLR(ASYNC_CLR)) u_chk (
  .clk   (clk),
  .clr_n (clr_n),
  .ld_n  (ld_n),
  .d     (d),
  .en    (en),
  .ci    (ci),
  .q     (q),
  .co    (co)
);

// File: tb/sim_pcnt_stage.sv
`timescale 1ns/1ps
module sim_pcnt_stage;

  logic clk;
  int   total;
  int   bad;
  bit   done;

  // u0: decade, synchronous clear
  logic       c0_r, short_mode, l0, e0, i0, co0;
  logic [3:0] d0, q0;
  logic       c0;
  assign c0 = short_mode ? (q0 != 4'd6) : c0_r;

  // u1: binary, asynchronous clear
  logic       c1, l1, e1, i1, co1;
  logic [3:0] d1, q1;

  // u2/u3: decade cascade, asynchronous clear
  logic       c2, en2, co2, co3;
  logic [3:0] q2, q3;

  pcnt_stage #(.W(4), .DECADE(1'b1), .ASYNC_CLR(1'b0)) u0 (
    .clk(clk), .clr_n(c0), .ld_n(l0), .d(d0), .en(e0), .ci(i0), .q(q0), .co(co0));

  pcnt_stage #(.W(4), .DECADE(1'b0), .ASYNC_CLR(1'b1)) u1 (
    .clk(clk), .clr_n(c1), .ld_n(l1), .d(d1), .en(e1), .ci(i1), .q(q1), .co(co1));

  pcnt_stage #(.W(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) u2 (
    .clk(clk), .clr_n(c2), .ld_n(1'b1), .d(4'd0), .en(en2), .ci(1'b1), .q(q2), .co(co2));

  pcnt_stage #(.W(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) u3 (
    .clk(clk), .clr_n(c2), .ld_n(1'b1), .d(4'd0), .en(en2), .ci(co2), .q(q3), .co(co3));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] model(input logic [3:0] q, input logic clr, input logic ld,
                                       input logic [3:0] d, input logic en, input logic ci,
                                       input bit dec);
    logic [3:0] term;
    term = dec ? 4'd9 : 4'd15;
    if (!clr)            return 4'd0;
    else if (!ld)        return d;
    else if (en && ci)   return (q == term) ? 4'd0 : q + 4'd1;
    else                 return q;
  endfunction

  task automatic edge_chk;
    @(posedge clk); #1;
  endtask

  logic [3:0] m0, m1;

  initial begin
    total = 0; bad = 0; done = 0;
    short_mode = 0;
    c0_r = 0; l0 = 1; e0 = 0; i0 = 0; d0 = 0;
    c1 = 0; l1 = 1; e1 = 0; i1 = 0; d1 = 0;
    c2 = 0; en2 = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R5 reset u0", q0, 0);
    chk("R5 reset u1", q1, 0);
    chk("R6 reset co u0", co0, 0);

    // ---- u0 directed: decade, sync clear ----
    @(negedge clk); c0_r = 1; l0 = 0; d0 = 4'd12; e0 = 0; i0 = 0;
    edge_chk(); chk("R4 load ignores en/ci", q0, 12);
    @(negedge clk); l0 = 1; e0 = 1; i0 = 1; #1;
    chk("R7 co low at 12", co0, 0);
    edge_chk(); chk("R7 12 counts to 13", q0, 13);
    @(negedge clk); l0 = 0; d0 = 4'd15;
    edge_chk(); chk("R7 load 15", q0, 15);
    @(negedge clk); l0 = 1; #1;
    chk("R7 co low at 15", co0, 0);
    edge_chk(); chk("R7 15 counts to 0", q0, 0);
    edge_chk(); chk("R1 0 counts to 1", q0, 1);
    @(negedge clk); l0 = 0; d0 = 4'd8;
    edge_chk(); chk("R4 load 8", q0, 8);
    @(negedge clk); l0 = 1;
    edge_chk(); chk("R1 8 counts to 9", q0, 9);
    chk("R6 co high at 9", co0, 1);
    @(negedge clk); i0 = 0; #1;
    chk("R6 co low when ci low", co0, 0);
    edge_chk(); chk("R3 hold with ci low", q0, 9);
    @(negedge clk); i0 = 1; e0 = 0;
    edge_chk(); chk("R3 hold with en low", q0, 9);
    @(negedge clk); e0 = 1;
    edge_chk(); chk("R2 decade 9 wraps to 0", q0, 0);
    @(negedge clk); l0 = 0; d0 = 4'd5;
    edge_chk(); chk("R4 load 5", q0, 5);
    @(negedge clk); c0_r = 0; l0 = 0; d0 = 4'd3; #1;
    chk("R5 sync clear waits for edge", q0, 5);
    edge_chk(); chk("R5 clear beats load", q0, 0);
    @(negedge clk); c0_r = 1; l0 = 1; short_mode = 1;
    for (int k = 1; k <= 14; k++) begin
      edge_chk(); chk("R9 short cycle 0..6", q0, k % 7);
    end
    @(negedge clk); short_mode = 0;

    // ---- u1 directed: binary, async clear ----
    @(negedge clk); c1 = 1; l1 = 0; d1 = 4'd14; e1 = 1; i1 = 1;
    edge_chk(); chk("R4 u1 load 14", q1, 14);
    @(negedge clk); l1 = 1;
    edge_chk(); chk("R1 u1 14 to 15", q1, 15);
    chk("R6 u1 co at 15", co1, 1);
    edge_chk(); chk("R2 binary 15 wraps to 0", q1, 0);
    @(negedge clk); l1 = 0; d1 = 4'd7;
    edge_chk(); chk("R4 u1 load 7", q1, 7);
    @(negedge clk); l1 = 1; e1 = 0; c1 = 0; #1;
    chk("R5 async clear without edge", q1, 0);
    @(negedge clk); c1 = 1;

    // ---- cascade ----
    @(negedge clk); c2 = 1; en2 = 1;
    repeat (123) @(posedge clk);
    #1;
    chk("R8 cascade 123 edges -> 23", q3 * 10 + q2, 23);
    repeat (76) @(posedge clk);
    #1;
    chk("R8 cascade reaches 99", q3 * 10 + q2, 99);
    chk("R8 upper co at 99", co3, 1);
    @(posedge clk); #1;
    chk("R8 cascade wraps to 00", q3 * 10 + q2, 0);

    // ---- random phase ----
    @(negedge clk); c0_r = 0; c1 = 0;
    @(posedge clk); #1;
    m0 = 0; m1 = 0;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      c0_r = ($urandom % 16) != 0; l0 = ($urandom % 8) != 0;
      e0 = ($urandom % 4) != 0;    i0 = ($urandom % 4) != 0; d0 = 4'($urandom);
      c1 = ($urandom % 16) != 0;   l1 = ($urandom % 8) != 0;
      e1 = ($urandom % 4) != 0;    i1 = ($urandom % 4) != 0; d1 = 4'($urandom);
      if (!c1) m1 = 0;
      #1;
      chk("R6 rand co u0", co0, int'(i0 && m0 == 4'd9));
      chk("R6 R5 rand co u1", co1, int'(i1 && m1 == 4'd15));
      m0 = model(m0, c0_r, l0, d0, e0, i0, 1'b1);
      m1 = model(m1, c1, l1, d1, e1, i1, 1'b0);
      edge_chk();
      chk("R1 R7 rand q u0", q0, m0);
      chk("R1 R2 rand q u1", q1, m1);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule